// File: doc/BRIEF.md
# Power-On Strap Sampling Sequencer

This block runs the start-up phase of three shared pins that serve first as configuration straps and later as clock outputs. When the supply-good indication rises, a settling timer counts a window (2 ms at the default clock). For that whole window the pin drivers stay in high impedance, so each external pull resistor alone sets its pin level. When the window ends, the synchronized pin levels are captured once. The captured bits then pick what the clocks do, and the drivers are turned on.

The sequence has three named states. `ST_SETTLE` counts the window. It moves to `ST_CAPTURE` on the terminal count. `ST_CAPTURE` lasts one cycle, loads the strap latch and moves to `ST_ACTIVE`. `ST_ACTIVE` has no exit. Only a drop of supply-good, which acts as an asynchronous power cycle, clears the state, the timer and the latch and returns the block to `ST_SETTLE`. The plain logic reset clears only the input synchronizer.

Top module: `strap_seq_top`

## Requirements
- R1: While the window is running, `ready` is 0 and every bit of `pin_oe` is 0.
- R2: `ready` goes to 1 in the cycle after the (WIN_CYC+1)-th rising clock edge that samples `supply_ok` high, where WIN_CYC = (REF_HZ/1e6)*WIN_US. It stays 0 after the WIN_CYC-th edge.
- R3: The latched bits equal the pin levels held during the window. Bit 0 (`pin_in[0]`) is the clock-select strap, bit 1 (`pin_in[1]`) is the spread strap and bit 2 (`pin_in[2]`) is the output-enable strap. A pull-down reads as 0 and a pull-up reads as 1.
- R4: Once `ready` is 1, later changes on `pin_in` leave `strap_q` unchanged.
- R5: Asserting `rst_n` low changes neither `strap_q` nor `ready`.
- R6: When `supply_ok` goes low, `ready`, `strap_q` and `pin_oe` clear at once without a clock edge. When it rises again, a complete new window follows, even if the drop came partway through a window.
- R7: `spread_en` = `ready` AND NOT `strap_q[1]`. A latched 0 turns spread spectrum on and a latched 1 turns it off.
- R8: `sel_24m` = `ready` AND `strap_q[0]`. A value of 1 puts 24 MHz on the selectable pin (pin 2) and a value of 0 puts 48 MHz there.
- R9: With `ready` = 1 and `strap_q[2]` = 1, `pin_oe` = 3'b111 and `outs_en` = 1. With `strap_q[2]` = 0, `pin_oe` = 0 and `outs_en` = 0.
- R10: `ref_copy[1:0]` follow the reference clock on pins 0 and 1 while their drivers are enabled, and are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Logic reset, active low; clears only the synchronizer |
| supply_ok | input | 1 | Supply-good indication; low acts as a power cycle |
| pin_in | input | 3 | Levels read from the three shared pins |
| pin_oe | output | 3 | Per-pin driver enable |
| strap_q | output | 3 | Latched straps: [0] select, [1] spread, [2] output enable |
| ready | output | 1 | Straps latched and sequence finished |
| outs_en | output | 1 | Enable for all clock outputs |
| spread_en | output | 1 | Spread spectrum on |
| sel_24m | output | 1 | Pin 2 carries 24 MHz (1) or 48 MHz (0) |
| ref_copy | output | 2 | Reference clock copies for pins 0 and 1 |

## Verification
Random 3-bit strap patterns are applied across repeated power-ups, so each of the eight encodings reaches the decode outputs. This separates a swapped bit order from a wrong decode polarity. Directed cases do three things. They probe the edge just before and the edge just after the window, which catches off-by-one errors in the timer. They drop supply partway through a window, which shows whether the count truly restarts. They toggle the pins and pulse the logic reset after latching, which separates a single capture from a latch that keeps tracking its input.

// File: rtl/strap_pkg.sv
package strap_pkg;
    typedef enum logic [1:0] {
        ST_SETTLE  = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_ACTIVE  = 2'd2
    } seq_state_t;

    localparam int STRAP_N    = 3;
    localparam int IDX_SEL    = 0;
    localparam int IDX_SPREAD = 1;
    localparam int IDX_OE     = 2;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end
        assign q[i] = stab_q;
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int WIN_CYC = 28000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (run && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         cap,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            q <= '0;
        end else if (cap) begin
            q <= d;
        end
    end
endmodule

// File: rtl/strap_seq_top.sv
module strap_seq_top
    import strap_pkg::*;
#(
    parameter int REF_HZ = 14_318_000,
    parameter int WIN_US = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic [2:0] pin_in,
    output logic [2:0] pin_oe,
    output logic [2:0] strap_q,
    output logic       ready,
    output logic       outs_en,
    output logic       spread_en,
    output logic       sel_24m,
    output logic [1:0] ref_copy
);
    localparam int CYC_PER_US = (REF_HZ >= 1_000_000) ? (REF_HZ / 1_000_000) : 1;
    localparam int WIN_CYC    = CYC_PER_US * WIN_US;

    seq_state_t state_q, state_d;
    logic [STRAP_N-1:0] pin_s;
    logic timer_run, timer_done, cap_en;
    logic sync_rst_n;

    assign sync_rst_n = rst_n && supply_ok;

    strap_sync #(.N(STRAP_N)) u_sync (
        .clk    (clk),
        .arst_n (sync_rst_n),
        .d      (pin_in),
        .q      (pin_s)
    );

    settle_timer #(.WIN_CYC(WIN_CYC)) u_timer (
        .clk    (clk),
        .arst_n (supply_ok),
        .run    (timer_run),
        .done   (timer_done)
    );

    strap_latch #(.N(STRAP_N)) u_latch (
        .clk    (clk),
        .arst_n (supply_ok),
        .cap    (cap_en),
        .d      (pin_s),
        .q      (strap_q)
    );

    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) begin
            state_q <= ST_SETTLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        timer_run = 1'b0;
        cap_en    = 1'b0;
        ready     = 1'b0;
        unique case (state_q)
            ST_SETTLE: begin
                timer_run = 1'b1;
                if (timer_done) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                cap_en  = 1'b1;
                state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                ready = 1'b1;
            end
            default: state_d = ST_SETTLE;
        endcase
    end

    assign outs_en   = ready && strap_q[IDX_OE];
    assign pin_oe    = {STRAP_N{outs_en}};
    assign spread_en = ready && !strap_q[IDX_SPREAD];
    assign sel_24m   = ready && strap_q[IDX_SEL];
    assign ref_copy  = {2{clk}} & pin_oe[1:0];
endmodule

// File: rtl/strap_seq_chk.sv
module strap_seq_chk (
    input logic       clk,
    input logic       supply_ok,
    input logic       ready,
    input logic [2:0] pin_oe,
    input logic [2:0] strap_q,
    input logic       outs_en,
    input logic       spread_en
);
    // R1: no driver enabled before the sequence finishes
    p_hiz_settle_r1: assert property (@(posedge clk) disable iff (!supply_ok)
        !ready |-> (pin_oe == 3'b000));

    // R4: latched straps never move once ready
    p_strap_hold_r4: assert property (@(posedge clk) disable iff (!supply_ok)
        (ready && $past(ready)) |-> $stable(strap_q));

    // R5: ready never falls while supply stays good
    p_ready_sticky_r5: assert property (@(posedge clk) disable iff (!supply_ok)
        $past(ready) |-> ready);

    // R6: nothing latched before the sequence finishes
    p_clear_before_r6: assert property (@(posedge clk) disable iff (!supply_ok)
        !ready |-> (strap_q == 3'b000));

    // R9: all drivers follow the output-enable strap
    p_oe_follow_r9: assert property (@(posedge clk) disable iff (!supply_ok)
        ready |-> (pin_oe == {3{strap_q[2]}} && outs_en == strap_q[2]));

    // R7: spread is off whenever the sequence is unfinished
    p_spread_gate_r7: assert property (@(posedge clk) disable iff (!supply_ok)
        !ready |-> !spread_en);
endmodule

bind strap_seq_top strap_seq_chk u_chk (
    .clk       (clk),
    .supply_ok (supply_ok),
    .ready     (ready),
    .pin_oe    (pin_oe),
    .strap_q   (strap_q),
    .outs_en   (outs_en),
    .spread_en (spread_en)
);

// File: tb/sim_strap_seq_top.sv
module sim_strap_seq_top;
    localparam int PER = 10;
    localparam int REF_HZ = 1_000_000;
    localparam int WIN_US = 20;
    localparam int WIN = (REF_HZ / 1_000_000) * WIN_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic [2:0] pin_in = 3'b000;
    logic [2:0] pin_oe, strap_q;
    logic ready, outs_en, spread_en, sel_24m;
    logic [1:0] ref_copy;

    int total = 0;
    int bad = 0;

    always #(PER/2) clk = ~clk;

    strap_seq_top #(.REF_HZ(REF_HZ), .WIN_US(WIN_US)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pin_in(pin_in),
        .pin_oe(pin_oe), .strap_q(strap_q), .ready(ready), .outs_en(outs_en),
        .spread_en(spread_en), .sel_24m(sel_24m), .ref_copy(ref_copy)
    );

    function automatic logic [2:0] exp_oe(logic [2:0] s, logic r);
        return {3{r & s[2]}};
    endfunction
    function automatic logic exp_spread(logic [2:0] s, logic r);
        return r & ~s[1];
    endfunction
    function automatic logic exp_sel(logic [2:0] s, logic r);
        return r & s[0];
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_decode(logic [2:0] s);
        chk("R3 strap", {5'd0, strap_q}, {5'd0, s});
        chk("R7 spread", {7'd0, spread_en}, {7'd0, exp_spread(s, 1'b1)});
        chk("R8 select", {7'd0, sel_24m}, {7'd0, exp_sel(s, 1'b1)});
        chk("R9 pin_oe", {5'd0, pin_oe}, {5'd0, exp_oe(s, 1'b1)});
        chk("R9 outs_en", {7'd0, outs_en}, {7'd0, s[2]});
    endtask

    // power up with given straps and check the window edges
    task automatic power_up(logic [2:0] s);
        @(negedge clk);
        pin_in = s;
        supply_ok = 1'b1;
        repeat (WIN) @(posedge clk);
        @(negedge clk);
        chk("R1 ready in window", {7'd0, ready}, 8'd0);
        chk("R1 pin_oe in window", {5'd0, pin_oe}, 8'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 ready after window", {7'd0, ready}, 8'd1);
        check_decode(s);
    endtask

    task automatic power_down();
        @(negedge clk);
        supply_ok = 1'b0;
        #1;
        chk("R6 ready cleared", {7'd0, ready}, 8'd0);
        chk("R6 strap cleared", {5'd0, strap_q}, 8'd0);
        chk("R6 pin_oe cleared", {5'd0, pin_oe}, 8'd0);
    endtask

    initial begin
        #(PER * 200000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2:0] s;
        void'($urandom(32'd1234));
        #1;
        chk("R6 reset ready", {7'd0, ready}, 8'd0);
        chk("R6 reset strap", {5'd0, strap_q}, 8'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // directed: all-zero and all-one straps
        power_up(3'b000);
        power_down();
        power_up(3'b111);
        // R10: reference copies follow the clock while enabled
        @(posedge clk); #(PER/4);
        chk("R10 ref high", {6'd0, ref_copy}, 8'd3);
        @(negedge clk); #(PER/4);
        chk("R10 ref low", {6'd0, ref_copy}, 8'd0);
        power_down();

        // random patterns with post-latch disturbance
        for (int it = 0; it < 10; it++) begin
            s = 3'($urandom);
            power_up(s);
            if (s[2] == 1'b0) begin
                @(posedge clk); #(PER/4);
                chk("R10 ref gated", {6'd0, ref_copy}, 8'd0);
            end
            // R4: pins move after latching
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                pin_in = 3'($urandom);
            end
            repeat (4) @(posedge clk);
            @(negedge clk);
            chk("R4 strap held", {5'd0, strap_q}, {5'd0, s});
            // R5: logic reset pulse
            rst_n = 1'b0;
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk("R5 strap under rst", {5'd0, strap_q}, {5'd0, s});
            chk("R5 ready under rst", {7'd0, ready}, 8'd1);
            rst_n = 1'b1;
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk("R5 strap after rst", {5'd0, strap_q}, {5'd0, s});
            power_down();
        end

        // R6: drop partway through a window, then a full new window
        @(negedge clk);
        pin_in = 3'b101;
        supply_ok = 1'b1;
        repeat (WIN / 2) @(posedge clk);
        power_down();
        power_up(3'b010);
        power_down();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule